// File: doc/BRIEF.md
# Multimode Up/Down Timer Channel

A 16-bit timer/counter channel whose count source is chosen by a small configuration port. Four sources are offered: a prescaled timer, a gated timer that advances only while an external gate sits at its active level (for pulse width and duty cycle measurement), an event counter driven by edges on an external input, and a quadrature decoder that reads the two external inputs as sensor phases A and B so that the count follows the sensor position.

Both external inputs are resynchronised by two flip-flops and then examined on a fixed grid of one look every four system clocks, which is also the finest count rate. The count direction comes from a software bit or from the level of the up/down input. Software can overwrite the count at any time, and the load wins over a count event in the same cycle. Wrapping past the top or the bottom of the range raises a one-cycle overflow or underflow pulse.

Top module: `updn_timer_chan`

## Requirements
- R1: While rstN is low the count is 0x0000 and ovfPulse and unfPulse are low; the grid phase counter and the prescaler counter restart from zero.
- R2: Timer mode (cfgMode = 0) with runEn high steps the count once every 4 * 2^cfgPrescale system clocks; cfgPrescale ranges over 0 to 7.
- R3: Gated mode (cfgMode = 1) steps like R2 but only on grid points where the sampled extClkGate equals the active level: high when cfgGateLow = 0, low when cfgGateLow = 1.
- R4: Counter mode (cfgMode = 2) steps once per grid point at which the sampled extClkGate differs from the previous sample in a direction enabled by cfgEdge: bit 0 enables rising, bit 1 enables falling (0 counts nothing, 3 counts both).
- R5: Quadrature mode (cfgMode = 3) treats extClkGate as phase A and extUpDn as phase B; a change of A alone counts when cfgEdge bit 0 is set, up if the new A differs from B, down otherwise; a change of B alone counts when cfgEdge bit 1 is set, up if A equals the new B, down otherwise; a simultaneous change of both counts nothing.
- R6: Outside quadrature mode the direction is cfgDown when cfgDirPin = 0 and the sampled level of extUpDn when cfgDirPin = 1, where 1 means down.
- R7: Each input passes two synchroniser flops; the grid phase counter advances every clock from 0 after reset and the count can change only on an edge at which the phase is 3 (the 4th, 8th, ... edge after reset release), using the synchronised values present at that edge; the previous sample is refreshed at the same edge.
- R8: With runEn low the count never steps and no wrap pulse occurs, in any mode.
- R9: loadEn high at a clock edge writes loadVal into the count at that edge, takes priority over a coincident step and raises no wrap pulse.
- R10: Stepping up from 0xFFFF gives 0x0000 and ovfPulse high for exactly the cycle after that edge.
- R11: Stepping down from 0x0000 gives 0xFFFF and unfPulse high for exactly the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgMode | input | 2 | 0 timer, 1 gated timer, 2 event counter, 3 quadrature |
| cfgPrescale | input | 3 | Timer/gated divider exponent n, step every 4*2^n clocks |
| cfgEdge | input | 2 | Edge enables (counter: rise/fall, quadrature: A/B) |
| cfgGateLow | input | 1 | Gate active level is low when set |
| cfgDirPin | input | 1 | Direction from extUpDn when set, else from cfgDown |
| cfgDown | input | 1 | Software direction, 1 counts down |
| runEn | input | 1 | Enables stepping |
| loadEn | input | 1 | Writes loadVal into the count |
| loadVal | input | 16 | Value written by loadEn |
| extClkGate | input | 1 | External clock, gate or phase A |
| extUpDn | input | 1 | External direction or phase B |
| countVal | output | 16 | Current count |
| ovfPulse | output | 1 | One-cycle pulse on upward wrap |
| unfPulse | output | 1 | One-cycle pulse on downward wrap |

## Verification
The assertions take for granted that loadEn is low during reset and that nothing but a load or a grid-point step moves the count, so any other change of countVal is a fault; they also rely on the grid phase restarting at reset release, which the checker mirrors with its own phase counter. The stimulus changes inputs only on falling clock edges and holds external levels for at least several grid periods, so each transition is seen at exactly one grid point and a reference model that delays inputs through two stages stays aligned with the synchroniser.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_GATED = 2'd1,
    MODE_COUNT = 2'd2,
    MODE_QUAD  = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic step;
    logic down;
  } tmrStrobe_t;

endpackage

// File: rtl/updn_timer_ctrl.sv
module updn_timer_ctrl
  import updn_timer_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int GRID        = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic [PRE_W-1:0] cfgPrescale,
  input  logic [1:0]       cfgEdge,
  input  logic             cfgGateLow,
  input  logic             cfgDirPin,
  input  logic             cfgDown,
  input  logic             runEn,
  input  logic             extClkGate,
  input  logic             extUpDn,
  output tmrStrobe_t       strobe
);

  localparam int GRID_W    = $clog2(GRID);
  localparam int PRE_CNT_W = (2 ** PRE_W) - 1;
  localparam logic [GRID_W-1:0] LAST_PHASE = GRID_W'(GRID - 1);

  // two-stage resynchronisers, one chain per input
  logic [SYNC_STAGES-1:0] chainA;
  logic [SYNC_STAGES-1:0] chainB;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chainA <= '0;
          chainB <= '0;
        end else begin
          chainA <= extClkGate;
          chainB <= extUpDn;
        end
      end
    end else begin : g_sync_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chainA <= '0;
          chainB <= '0;
        end else begin
          chainA <= {chainA[SYNC_STAGES-2:0], extClkGate};
          chainB <= {chainB[SYNC_STAGES-2:0], extUpDn};
        end
      end
    end
  endgenerate

  logic syncA;
  logic syncB;
  assign syncA = chainA[SYNC_STAGES-1];
  assign syncB = chainB[SYNC_STAGES-1];

  // sampling grid
  logic [GRID_W-1:0] phase;
  logic              gridTick;
  assign gridTick = (phase == LAST_PHASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + GRID_W'(1);
  end

  // previous samples for edge detection
  logic prevA;
  logic prevB;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else if (gridTick) begin
      prevA <= syncA;
      prevB <= syncB;
    end
  end

  // prescaler counts grid points
  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preMask;
  logic                 preHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         preCnt <= '0;
    else if (gridTick) preCnt <= preCnt + PRE_CNT_W'(1);
  end

  always_comb begin
    for (int i = 0; i < PRE_CNT_W; i++) begin
      preMask[i] = (PRE_W'(i) < cfgPrescale);
    end
  end

  assign preHit = ((preCnt & preMask) == preMask);

  // event decode
  logic riseA;
  logic fallA;
  logic chgA;
  logic chgB;
  logic gateOpen;
  logic swDown;

  assign riseA    = syncA & ~prevA;
  assign fallA    = ~syncA & prevA;
  assign chgA     = syncA ^ prevA;
  assign chgB     = syncB ^ prevB;
  assign gateOpen = syncA ^ cfgGateLow;
  assign swDown   = cfgDirPin ? syncB : cfgDown;

  tmrMode_e modeSel;
  assign modeSel = tmrMode_e'(cfgMode);

  always_comb begin
    strobe.step = 1'b0;
    strobe.down = swDown;
    unique case (modeSel)
      MODE_TIMER: strobe.step = preHit;
      MODE_GATED: strobe.step = preHit & gateOpen;
      MODE_COUNT: strobe.step = (riseA & cfgEdge[0]) | (fallA & cfgEdge[1]);
      MODE_QUAD: begin
        if (chgA && !chgB) begin
          strobe.step = cfgEdge[0];
          strobe.down = (syncA == syncB);
        end else if (chgB && !chgA) begin
          strobe.step = cfgEdge[1];
          strobe.down = (syncA != syncB);
        end
      end
      default: strobe.step = 1'b0;
    endcase
    strobe.step = strobe.step & gridTick & runEn;
  end

endmodule

// File: rtl/updn_timer_dp.sv
module updn_timer_dp
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countVal,
  output logic             ovfPulse,
  output logic             unfPulse
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP  = '1;
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] nextVal;
  logic             wrapUp;
  logic             wrapDown;

  always_comb begin
    nextVal  = countVal;
    wrapUp   = 1'b0;
    wrapDown = 1'b0;
    if (loadEn) begin
      nextVal = loadVal;
    end else if (strobe.step) begin
      if (strobe.down) begin
        nextVal  = countVal - ONE;
        wrapDown = (countVal == ZERO);
      end else begin
        nextVal  = countVal + ONE;
        wrapUp   = (countVal == TOP);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
    end else begin
      countVal <= nextVal;
      ovfPulse <= wrapUp;
      unfPulse <= wrapDown;
    end
  end

endmodule

// File: rtl/updn_timer_chan.sv
module updn_timer_chan
  import updn_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int GRID        = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic [PRE_W-1:0] cfgPrescale,
  input  logic [1:0]       cfgEdge,
  input  logic             cfgGateLow,
  input  logic             cfgDirPin,
  input  logic             cfgDown,
  input  logic             runEn,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             extClkGate,
  input  logic             extUpDn,
  output logic [CNT_W-1:0] countVal,
  output logic             ovfPulse,
  output logic             unfPulse
);

  tmrStrobe_t strobe;

  updn_timer_ctrl #(
    .PRE_W      (PRE_W),
    .SYNC_STAGES(SYNC_STAGES),
    .GRID       (GRID)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgMode    (cfgMode),
    .cfgPrescale(cfgPrescale),
    .cfgEdge    (cfgEdge),
    .cfgGateLow (cfgGateLow),
    .cfgDirPin  (cfgDirPin),
    .cfgDown    (cfgDown),
    .runEn      (runEn),
    .extClkGate (extClkGate),
    .extUpDn    (extUpDn),
    .strobe     (strobe)
  );

  updn_timer_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadEn  (loadEn),
    .loadVal (loadVal),
    .countVal(countVal),
    .ovfPulse(ovfPulse),
    .unfPulse(unfPulse)
  );

endmodule

// File: rtl/updn_timer_chan_chk.sv
module updn_timer_chan_chk #(
  parameter int CNT_W = 16,
  parameter int GRID  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             loadEn,
  input logic [CNT_W-1:0] loadVal,
  input logic [CNT_W-1:0] countVal,
  input logic             ovfPulse,
  input logic             unfPulse
);

  localparam int GRID_W = $clog2(GRID);

  logic [GRID_W-1:0] chkPhase;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkPhase <= '0;
    else       chkPhase <= chkPhase + GRID_W'(1);
  end

  // R9: load wins and lands at the next edge
  a_r9_load_priority: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (countVal == $past(loadVal)) && !ovfPulse && !unfPulse);

  // R10: overflow pulse only on an upward wrap
  a_r10_ovf_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (countVal == '0) && ($past(countVal) == '1));

  // R11: underflow pulse only on a downward wrap
  a_r11_unf_wrap: assert property (@(posedge clk) disable iff (!rstN)
    unfPulse |-> (countVal == '1) && ($past(countVal) == '0));

  // R10/R11: never both pulses
  a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfPulse && unfPulse));

  // R7: non-load changes happen only on grid points
  a_r7_grid_only: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(loadEn) && (countVal != $past(countVal))) |->
      ($past(chkPhase) == GRID_W'(GRID - 1)));

  // R2: non-load changes are single steps
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(loadEn) && (countVal != $past(countVal))) |->
      ((countVal == $past(countVal) + CNT_W'(1)) ||
       (countVal == $past(countVal) - CNT_W'(1))));

  // R8: halted channel holds its count
  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(runEn) && !$past(loadEn)) |-> ($stable(countVal) && !ovfPulse && !unfPulse));

endmodule

bind updn_timer_chan updn_timer_chan_chk #(
  .CNT_W(CNT_W),
  .GRID (GRID)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .runEn   (runEn),
  .loadEn  (loadEn),
  .loadVal (loadVal),
  .countVal(countVal),
  .ovfPulse(ovfPulse),
  .unfPulse(unfPulse)
);

// File: tb/updn_timer_chan_bench.sv
module updn_timer_chan_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  cfgMode;
  logic [2:0]  cfgPrescale;
  logic [1:0]  cfgEdge;
  logic        cfgGateLow;
  logic        cfgDirPin;
  logic        cfgDown;
  logic        runEn;
  logic        loadEn;
  logic [15:0] loadVal;
  logic        extClkGate;
  logic        extUpDn;
  logic [15:0] countVal;
  logic        ovfPulse;
  logic        unfPulse;

  always #(CLK_PERIOD / 2) clk = ~clk;

  updn_timer_chan u_updn_timer_chan (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgPrescale(cfgPrescale),
    .cfgEdge(cfgEdge), .cfgGateLow(cfgGateLow), .cfgDirPin(cfgDirPin),
    .cfgDown(cfgDown), .runEn(runEn), .loadEn(loadEn), .loadVal(loadVal),
    .extClkGate(extClkGate), .extUpDn(extUpDn), .countVal(countVal),
    .ovfPulse(ovfPulse), .unfPulse(unfPulse)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  int    nOvf    = 0;
  int    nUnf    = 0;
  string curReq  = "R1";

  // behavioural reference: input histories and the count
  bit    histA[$];
  bit    histB[$];
  int    refEdges = 0;
  int    refCount = 0;
  bit    refOvf = 0;
  bit    refUnf = 0;
  bit    lastA = 0;
  bit    lastB = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      histA = {}; histB = {};
      refEdges = 0; refCount = 0; refOvf = 0; refUnf = 0;
      lastA = 0; lastB = 0;
    end else begin
      bit a, b, go, dn;
      int gridIdx, span;
      a = (histA.size() >= 2) ? histA[histA.size()-2] : 1'b0;
      b = (histB.size() >= 2) ? histB[histB.size()-2] : 1'b0;
      go = 0;
      dn = cfgDirPin ? b : cfgDown;
      refOvf = 0; refUnf = 0;
      if (refEdges % 4 == 3) begin
        gridIdx = refEdges / 4;
        span = 1 << cfgPrescale;
        case (cfgMode)
          2'd0: go = ((gridIdx % 128) % span) == span - 1;
          2'd1: go = (((gridIdx % 128) % span) == span - 1) && (a == !cfgGateLow);
          2'd2: go = (a && !lastA && cfgEdge[0]) || (!a && lastA && cfgEdge[1]);
          default: begin
            if (a != lastA && b == lastB) begin go = cfgEdge[0]; dn = (a == b); end
            else if (b != lastB && a == lastA) begin go = cfgEdge[1]; dn = (a != b); end
          end
        endcase
        go = go && runEn;
        lastA = a; lastB = b;
      end
      if (loadEn) refCount = loadVal;
      else if (go) begin
        if (dn) begin
          if (refCount == 0) begin refCount = 65535; refUnf = 1; end
          else refCount = refCount - 1;
        end else begin
          if (refCount == 65535) begin refCount = 0; refOvf = 1; end
          else refCount = refCount + 1;
        end
      end
      histA.push_back(extClkGate);
      histB.push_back(extUpDn);
      if (histA.size() > 4) begin void'(histA.pop_front()); void'(histB.pop_front()); end
      refEdges++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareNow();
    check(curReq, "countVal", countVal, refCount);
    check(curReq, "ovfPulse", ovfPulse, refOvf);
    check(curReq, "unfPulse", unfPulse, refUnf);
    if (ovfPulse) nOvf++;
    if (unfPulse) nUnf++;
  endtask

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compareNow();
    end
  endtask

  task automatic runToggle(int cycles, int half);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compareNow();
      if ((i + 1) % half == 0) extClkGate = ~extClkGate;
    end
  endtask

  task automatic quadSteps(int steps, bit fwd, int hold);
    for (int s = 0; s < steps; s++) begin
      run(hold);
      // forward order of (A,B): 00,10,11,01
      if (fwd) begin
        if (extClkGate == extUpDn) extClkGate = ~extClkGate; else extUpDn = ~extUpDn;
      end else begin
        if (extClkGate == extUpDn) extUpDn = ~extUpDn; else extClkGate = ~extClkGate;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int held;
    rstN = 0; cfgMode = 0; cfgPrescale = 0; cfgEdge = 0; cfgGateLow = 0;
    cfgDirPin = 0; cfgDown = 0; runEn = 0; loadEn = 0; loadVal = 0;
    extClkGate = 0; extUpDn = 0;
    repeat (5) @(negedge clk);
    check("R1", "reset count", countVal, 0);
    check("R1", "reset ovf", ovfPulse, 0);
    check("R1", "reset unf", unfPulse, 0);
    rstN = 1;

    // timer, fastest rate, up
    curReq = "R2"; runEn = 1;
    run(3);
    check("R7", "no step before 4th edge", countVal, 0);
    run(1);
    check("R7", "step on 4th edge", countVal, 1);
    run(60);
    cfgPrescale = 2; cfgDown = 1; curReq = "R6";
    run(120);
    cfgPrescale = 7; curReq = "R2";
    run(1100);

    // wrap up and down
    curReq = "R10"; cfgPrescale = 0; cfgDown = 0;
    loadEn = 1; loadVal = 16'hFFFD; run(1); loadEn = 0;
    run(40);
    curReq = "R11"; cfgDown = 1;
    loadEn = 1; loadVal = 16'h0002; run(1); loadEn = 0;
    run(40);

    // load priority over steps on every phase
    curReq = "R9";
    for (int k = 0; k < 4; k++) begin
      loadEn = 1; loadVal = 16'h1230 + 16'(k);
      @(negedge clk);
      compareNow();
      check("R9", "load value", countVal, 16'h1230 + k);
      loadEn = 0;
    end

    // gated timer, both polarities
    curReq = "R3"; cfgMode = 1; cfgDown = 0; cfgPrescale = 1;
    runToggle(200, 23);
    cfgGateLow = 1;
    runToggle(200, 31);
    cfgGateLow = 0; extClkGate = 0;
    run(40);

    // event counter, edge selections, direction from pin
    curReq = "R4"; cfgMode = 2;
    for (int e = 0; e < 4; e++) begin
      cfgEdge = 2'(e);
      runToggle(180, 9);
    end
    curReq = "R6"; cfgDirPin = 1; cfgEdge = 2'd3;
    for (int p = 0; p < 4; p++) begin
      extUpDn = ~extUpDn;
      runToggle(120, 11);
    end
    cfgDirPin = 0; extUpDn = 0; extClkGate = 0;
    run(20);

    // quadrature decode
    curReq = "R5"; cfgMode = 3; cfgEdge = 2'd3;
    loadEn = 1; loadVal = 16'h0003; run(1); loadEn = 0;
    quadSteps(12, 1, 10);
    quadSteps(20, 0, 9);
    cfgEdge = 2'd1; quadSteps(8, 1, 12);
    cfgEdge = 2'd2; quadSteps(8, 0, 12);
    cfgEdge = 2'd3;
    run(6);
    extClkGate = ~extClkGate; extUpDn = ~extUpDn;
    held = countVal;
    run(12);
    check("R5", "simultaneous change ignored", countVal, held);

    // halted channel ignores all activity
    curReq = "R8"; runEn = 0; cfgMode = 2;
    held = countVal;
    runToggle(100, 5);
    check("R8", "count held while halted", countVal, held);
    cfgMode = 0;
    run(60);
    check("R8", "timer held while halted", countVal, held);

    check("R10", "overflow seen", (nOvf > 0) ? 1 : 0, 1);
    check("R11", "underflow seen", (nUnf > 0) ? 1 : 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule